// File: doc/BRIEF.md
# Calendar Clock with Time-of-Day Alarm

This block keeps a wall-clock calendar (seconds, minutes, hours, day of week, day of month, month and a two-digit year) and advances it by one second each time an external once-per-second tick arrives. Month lengths are exact, and February follows the Gregorian leap rule computed from a base year plus the two-digit year field. After every completed advance, the new time is compared against a three-field alarm.

Each time register is presented either in packed BCD or in plain binary. The hour is presented in 24-hour form or in 12-hour form with a PM flag. The advance runs only while the oscillator control field holds the run code and the hold control is low. Each advance opens an update-in-progress window of a fixed number of clock cycles. At the end of the window the visible registers change, and single-cycle strobes report the update and any alarm hit. A simple field-load port sets the time and the alarm.

Top module: `rtc_calendar`

## Requirements
- R1: After synchronous reset, in BCD 24-hour mode, the outputs read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00, and `uip` and all strobes are low.
- R2: A `sec_tick` opens an update window only when `osc_sel` equals 3'b010 and `set_mode` is low. Any other tick is ignored: `uip` stays low, no strobe fires and the time does not change.
- R3: `uip` rises in the cycle after an accepted tick and stays high for exactly `UIP_CYCLES` cycles. The time registers and strobes change on the edge where `uip` falls. Ticks that arrive inside the window are ignored.
- R4: Seconds and minutes wrap at 60 and hours wrap at 24, each carrying into the next field. The weekday runs 1 to 7 and wraps from 7 to 1 on a day change. The month wraps from 12 to 1 and increments the year, and the year wraps from 99 to 0.
- R5: April, June, September and November have 30 days and the other months have 31, except February. February has 29 days when BASE_YEAR+year is divisible by 4 and either not by 100 or by 400, and 28 days otherwise (with default base 2000: year 00 and 24 are leap years, 23 is not).
- R6: With `bin_mode`=0 a value v is shown as {tens,units} BCD nibbles. With `bin_mode`=1 it is shown unchanged. Writes are decoded in the mode in force, and a mode change re-encodes the visible registers on the next edge.
- R7: With `hr24`=0, hour bit 7 is 1 for hours 12 to 23 and the low bits hold hour mod 12, with 0 shown as 12. A loaded 12 with bit 7 clear means hour 0, and a loaded 12 with bit 7 set means hour 12.
- R8: An alarm byte whose bits [7:6] are both 1 matches any value. Otherwise the decoded alarm must equal the new time in seconds, minutes and hours. A full match at an update pulses `alarm_flag` together with `update_flag`, and only when `alarm_ie` is 1.
- R9: Every completed update pulses `update_flag` for one cycle. `irq_flag` pulses with it when `update_ie` is 1 or when `alarm_flag` pulses.
- R10: A load (`wr_en`) in the last window cycle takes priority over the update. Only the loaded field changes, the second is not advanced and no strobe fires.
- R11: Raising `set_mode` during a window aborts it: `uip` drops on the next edge and no update or strobe occurs.
- R12: Load selects: 0 seconds, 1 alarm seconds, 2 minutes, 3 alarm minutes, 4 hours, 5 alarm hours, 6 weekday, 7 date, 8 month, 9 year. Other selects have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| osc_sel | input | 3 | Oscillator control; 3'b010 lets time run |
| set_mode | input | 1 | Holds the calendar and aborts an open window |
| bin_mode | input | 1 | 1 = binary registers, 0 = BCD |
| hr24 | input | 1 | 1 = 24-hour form, 0 = 12-hour with PM bit |
| alarm_ie | input | 1 | Enables the alarm strobe |
| update_ie | input | 1 | Lets each update raise the interrupt strobe |
| wr_en | input | 1 | Field load strobe |
| wr_sel | input | 4 | Field select for a load |
| wr_data | input | 8 | Load value in the current encoding |
| sec_q | output | 8 | Seconds register |
| min_q | output | 8 | Minutes register |
| hour_q | output | 8 | Hours register |
| wday_q | output | 8 | Day-of-week register |
| mday_q | output | 8 | Day-of-month register |
| mon_q | output | 8 | Month register |
| year_q | output | 8 | Two-digit year register |
| uip | output | 1 | Update in progress |
| update_flag | output | 1 | Update-ended strobe |
| alarm_flag | output | 1 | Alarm strobe |
| irq_flag | output | 1 | Interrupt strobe |

## Verification
The assertions check the handshake rules on every cycle. They confirm that a window opens only under the run code with hold low, that it never outlasts `UIP_CYCLES`, and that strobes appear only as `uip` falls. They also confirm that a load or a hold suppresses the update, and that alarm and interrupt strobes always have an enabling cause. The arithmetic can only be shown by the bench scenarios: the carry chain at year end, the month lengths and leap years, the BCD and binary encodings, the 12-hour noon and midnight cases, and whether the alarm matches the new time.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_t;

  localparam cal_t CAL_RESET = '{year: 7'd0, mon: 4'd1, mday: 5'd1, wday: 3'd1,
                                 hour: 5'd0, min: 6'd0, sec: 6'd0};

  localparam logic [2:0] OSC_RUN = 3'b010;

  localparam logic [3:0] FLD_SEC   = 4'd0;
  localparam logic [3:0] FLD_ASEC  = 4'd1;
  localparam logic [3:0] FLD_MIN   = 4'd2;
  localparam logic [3:0] FLD_AMIN  = 4'd3;
  localparam logic [3:0] FLD_HOUR  = 4'd4;
  localparam logic [3:0] FLD_AHOUR = 4'd5;
  localparam logic [3:0] FLD_WDAY  = 4'd6;
  localparam logic [3:0] FLD_MDAY  = 4'd7;
  localparam logic [3:0] FLD_MON   = 4'd8;
  localparam logic [3:0] FLD_YEAR  = 4'd9;

  // value 0..99 to register byte
  function automatic logic [7:0] to_reg(input logic [6:0] v, input logic bin);
    logic [3:0] t;
    logic [3:0] o;
    t = 4'(v / 7'd10);
    o = 4'(v % 7'd10);
    return bin ? {1'b0, v} : {t, o};
  endfunction

  // register byte to value
  function automatic logic [6:0] from_reg(input logic [7:0] r, input logic bin);
    logic [6:0] tens;
    tens = {3'b000, r[7:4]};
    return bin ? r[6:0] : (tens * 7'd10 + {3'b000, r[3:0]});
  endfunction

  function automatic logic [7:0] hour_to_reg(input logic [4:0] h, input logic bin,
                                             input logic h24);
    logic [4:0] h12;
    logic [7:0] r;
    if (h24) begin
      r = to_reg({2'b00, h}, bin);
    end else begin
      h12 = (h >= 5'd12) ? h - 5'd12 : h;
      if (h12 == 5'd0) h12 = 5'd12;
      r = to_reg({2'b00, h12}, bin);
      r[7] = (h >= 5'd12);
    end
    return r;
  endfunction

  function automatic logic [4:0] hour_from_reg(input logic [7:0] r, input logic bin,
                                               input logic h24);
    logic [6:0] v;
    if (h24) begin
      v = from_reg(r, bin);
    end else begin
      v = from_reg({1'b0, r[6:0]}, bin);
      if (v == 7'd12) v = 7'd0;
      if (r[7]) v = v + 7'd12;
    end
    return v[4:0];
  endfunction

  function automatic logic [4:0] days_in_month(input logic [3:0] mon, input logic [6:0] yr,
                                               input int base);
    int   full;
    logic leap;
    full = base + int'(yr);
    leap = ((full % 4) == 0) && (((full % 100) != 0) || ((full % 400) == 0));
    case (mon)
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      4'd2:                    return leap ? 5'd29 : 5'd28;
      default:                 return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cal_seq.sv
module rtc_cal_seq #(
  parameter int UIP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic sec_tick,
  input  logic osc_ok,
  input  logic set_mode,
  output logic uip,
  output logic step
);
  localparam int CW = $clog2(UIP_CYCLES + 1);

  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (set_mode) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CW'(1);
    end else if (sec_tick && osc_ok) begin
      busy <= 1'b1;
      cnt  <= CW'(UIP_CYCLES - 1);
    end
  end

  assign uip  = busy;
  assign step = busy && (cnt == '0) && !set_mode;

endmodule

// File: rtl/rtc_cal_time.sv
module rtc_cal_time
  import rtc_cal_pkg::*;
#(
  parameter int BASE_YEAR = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       wr_en,
  input  logic [3:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       bin_mode,
  input  logic       hr24,
  output cal_t       nxt
);
  cal_t       cur;
  cal_t       adv;
  logic [6:0] wv;
  logic [4:0] dim;

  always_comb begin
    adv = cur;
    dim = days_in_month(cur.mon, cur.year, BASE_YEAR);
    if (cur.sec < 6'd59) begin
      adv.sec = cur.sec + 6'd1;
    end else begin
      adv.sec = 6'd0;
      if (cur.min < 6'd59) begin
        adv.min = cur.min + 6'd1;
      end else begin
        adv.min = 6'd0;
        if (cur.hour < 5'd23) begin
          adv.hour = cur.hour + 5'd1;
        end else begin
          adv.hour = 5'd0;
          adv.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
          if (cur.mday < dim) begin
            adv.mday = cur.mday + 5'd1;
          end else begin
            adv.mday = 5'd1;
            if (cur.mon < 4'd12) begin
              adv.mon = cur.mon + 4'd1;
            end else begin
              adv.mon  = 4'd1;
              adv.year = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    wv  = from_reg(wr_data, bin_mode);
    nxt = cur;
    if (wr_en) begin
      case (wr_sel)
        FLD_SEC:  nxt.sec  = wv[5:0];
        FLD_MIN:  nxt.min  = wv[5:0];
        FLD_HOUR: nxt.hour = hour_from_reg(wr_data, bin_mode, hr24);
        FLD_WDAY: nxt.wday = wv[2:0];
        FLD_MDAY: nxt.mday = wv[4:0];
        FLD_MON:  nxt.mon  = wv[3:0];
        FLD_YEAR: nxt.year = wv;
        default:  nxt = cur;
      endcase
    end else if (step) begin
      nxt = adv;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= CAL_RESET;
    else     cur <= nxt;
  end

endmodule

// File: rtl/rtc_cal_alarm.sv
module rtc_cal_alarm
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [3:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       bin_mode,
  input  logic       hr24,
  input  logic [5:0] t_sec,
  input  logic [5:0] t_min,
  input  logic [4:0] t_hour,
  output logic       hit
);
  logic [7:0] a_sec, a_min, a_hour;
  logic       sec_ok, min_ok, hour_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sec  <= 8'h00;
      a_min  <= 8'h00;
      a_hour <= 8'h00;
    end else if (wr_en) begin
      if (wr_sel == FLD_ASEC)  a_sec  <= wr_data;
      if (wr_sel == FLD_AMIN)  a_min  <= wr_data;
      if (wr_sel == FLD_AHOUR) a_hour <= wr_data;
    end
  end

  always_comb begin
    sec_ok  = (a_sec[7:6]  == 2'b11) || (from_reg(a_sec, bin_mode) == {1'b0, t_sec});
    min_ok  = (a_min[7:6]  == 2'b11) || (from_reg(a_min, bin_mode) == {1'b0, t_min});
    hour_ok = (a_hour[7:6] == 2'b11) || (hour_from_reg(a_hour, bin_mode, hr24) == t_hour);
    hit     = sec_ok && min_ok && hour_ok;
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int UIP_CYCLES = 8,
  parameter int BASE_YEAR  = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sec_tick,
  input  logic [2:0] osc_sel,
  input  logic       set_mode,
  input  logic       bin_mode,
  input  logic       hr24,
  input  logic       alarm_ie,
  input  logic       update_ie,
  input  logic       wr_en,
  input  logic [3:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic [7:0] wday_q,
  output logic [7:0] mday_q,
  output logic [7:0] mon_q,
  output logic [7:0] year_q,
  output logic       uip,
  output logic       update_flag,
  output logic       alarm_flag,
  output logic       irq_flag
);
  logic step;
  logic upd;
  logic hit;
  cal_t nxt;

  rtc_cal_seq #(.UIP_CYCLES(UIP_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .osc_ok(osc_sel == OSC_RUN),
    .set_mode(set_mode), .uip(uip), .step(step)
  );

  rtc_cal_time #(.BASE_YEAR(BASE_YEAR)) u_time (
    .clk(clk), .rst(rst), .step(step), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .bin_mode(bin_mode), .hr24(hr24), .nxt(nxt)
  );

  rtc_cal_alarm u_alarm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .bin_mode(bin_mode), .hr24(hr24), .t_sec(nxt.sec), .t_min(nxt.min),
    .t_hour(nxt.hour), .hit(hit)
  );

  assign upd = step && !wr_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q       <= 8'h00;
      min_q       <= 8'h00;
      hour_q      <= 8'h00;
      wday_q      <= 8'h01;
      mday_q      <= 8'h01;
      mon_q       <= 8'h01;
      year_q      <= 8'h00;
      update_flag <= 1'b0;
      alarm_flag  <= 1'b0;
      irq_flag    <= 1'b0;
    end else begin
      sec_q       <= to_reg({1'b0, nxt.sec}, bin_mode);
      min_q       <= to_reg({1'b0, nxt.min}, bin_mode);
      hour_q      <= hour_to_reg(nxt.hour, bin_mode, hr24);
      wday_q      <= to_reg({4'b0000, nxt.wday}, bin_mode);
      mday_q      <= to_reg({2'b00, nxt.mday}, bin_mode);
      mon_q       <= to_reg({3'b000, nxt.mon}, bin_mode);
      year_q      <= to_reg(nxt.year, bin_mode);
      update_flag <= upd;
      alarm_flag  <= upd && alarm_ie && hit;
      irq_flag    <= upd && ((alarm_ie && hit) || update_ie);
    end
  end

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter int UIP_CYCLES = 8
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] osc_sel,
  input logic       set_mode,
  input logic       alarm_ie,
  input logic       update_ie,
  input logic       wr_en,
  input logic       uip,
  input logic       update_flag,
  input logic       alarm_flag,
  input logic       irq_flag
);
  localparam int RW = $clog2(UIP_CYCLES + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)      run <= '0;
    else if (uip) run <= run + RW'(1);
    else          run <= '0;
  end

  AST_OPEN_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(uip) |-> ($past(osc_sel) == 3'b010) && !$past(set_mode)); // R2
  AST_WINDOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
    uip |-> (run < RW'(UIP_CYCLES))); // R3
  AST_STROBE_AT_CLOSE: assert property (@(posedge clk) disable iff (rst)
    update_flag |-> $fell(uip)); // R3
  AST_ALARM_ENABLED: assert property (@(posedge clk) disable iff (rst)
    alarm_flag |-> $past(alarm_ie) && update_flag); // R8
  AST_UPDATE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    update_flag |=> !update_flag); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_flag |-> alarm_flag || (update_flag && $past(update_ie))); // R9
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    update_flag |-> !$past(wr_en)); // R10
  AST_HOLD_ABORTS: assert property (@(posedge clk) disable iff (rst)
    (set_mode && uip) |=> !uip && !update_flag); // R11

endmodule

bind rtc_calendar rtc_calendar_chk #(.UIP_CYCLES(UIP_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .osc_sel(osc_sel), .set_mode(set_mode),
  .alarm_ie(alarm_ie), .update_ie(update_ie), .wr_en(wr_en), .uip(uip),
  .update_flag(update_flag), .alarm_flag(alarm_flag), .irq_flag(irq_flag)
);

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;
  localparam int UIPC = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_tick = 1'b0;
  logic [2:0] osc_sel = 3'b010;
  logic       set_mode = 1'b0;
  logic       bin_mode = 1'b0;
  logic       hr24 = 1'b1;
  logic       alarm_ie = 1'b0;
  logic       update_ie = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_sel = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] sec_q, min_q, hour_q, wday_q, mday_q, mon_q, year_q;
  logic       uip, update_flag, alarm_flag, irq_flag;

  always #4 clk = ~clk;

  rtc_calendar #(.UIP_CYCLES(UIP_CYCLES_T), .BASE_YEAR(2000)) i_rtc_calendar (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .osc_sel(osc_sel), .set_mode(set_mode),
    .bin_mode(bin_mode), .hr24(hr24), .alarm_ie(alarm_ie), .update_ie(update_ie),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .sec_q(sec_q), .min_q(min_q),
    .hour_q(hour_q), .wday_q(wday_q), .mday_q(mday_q), .mon_q(mon_q), .year_q(year_q),
    .uip(uip), .update_flag(update_flag), .alarm_flag(alarm_flag), .irq_flag(irq_flag)
  );
  localparam int UIP_CYCLES_T = UIPC;

  typedef struct {
    logic [7:0] s, m, h, wd, md, mo, y;
    logic       al, ir;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   nchk = 0;
  int   nfail = 0;
  int   ms, mm, mh, mwd, mmd, mmo, my;
  int   al_s = 0, al_m = 0, al_h = 0;

  function automatic logic [7:0] enc(input int v);
    return bin_mode ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] ench(input int h);
    int         h12;
    logic [7:0] r;
    if (hr24) return enc(h);
    h12 = h % 12;
    if (h12 == 0) h12 = 12;
    r = enc(h12);
    if (h >= 12) r = r | 8'h80;
    return r;
  endfunction

  function automatic int dim(input int mo, input int y);
    int full;
    full = 2000 + y;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    if (mo == 2) return (((full % 4) == 0) && (((full % 100) != 0) || ((full % 400) == 0))) ? 29 : 28;
    return 31;
  endfunction

  task automatic model_adv();
    ms = ms + 1;
    if (ms == 60) begin
      ms = 0; mm = mm + 1;
      if (mm == 60) begin
        mm = 0; mh = mh + 1;
        if (mh == 24) begin
          mh = 0;
          mwd = (mwd == 7) ? 1 : mwd + 1;
          if (mmd == dim(mmo, my)) begin
            mmd = 1;
            if (mmo == 12) begin mmo = 1; my = (my == 99) ? 0 : my + 1; end
            else mmo = mmo + 1;
          end else mmd = mmd + 1;
        end
      end
    end
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check_now(input string tag);
    check8({tag, " sec"},  sec_q,  enc(ms));
    check8({tag, " min"},  min_q,  enc(mm));
    check8({tag, " hour"}, hour_q, ench(mh));
    check8({tag, " wday"}, wday_q, enc(mwd));
    check8({tag, " mday"}, mday_q, enc(mmd));
    check8({tag, " mon"},  mon_q,  enc(mmo));
    check8({tag, " year"}, year_q, enc(my));
  endtask

  task automatic wr(input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_time(input int h, input int m, input int s, input int wd,
                          input int md, input int mo, input int y);
    ms = s; mm = m; mh = h; mwd = wd; mmd = md; mmo = mo; my = y;
    wr(4'd0, enc(s)); wr(4'd2, enc(m)); wr(4'd4, ench(h));
    wr(4'd6, enc(wd)); wr(4'd7, enc(md)); wr(4'd8, enc(mo)); wr(4'd9, enc(y));
  endtask

  task automatic pulse_tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  // driver: push the expected result, then tick and measure the window
  task automatic tick_expect(input string tag);
    exp_t e;
    int   n;
    logic hit;
    model_adv();
    hit = ((al_s < 0) || (al_s == ms)) && ((al_m < 0) || (al_m == mm)) && ((al_h < 0) || (al_h == mh));
    e.s = enc(ms); e.m = enc(mm); e.h = ench(mh); e.wd = enc(mwd);
    e.md = enc(mmd); e.mo = enc(mmo); e.y = enc(my);
    e.al = alarm_ie && hit;
    e.ir = (alarm_ie && hit) || update_ie;
    e.tag = tag;
    q.push_back(e);
    pulse_tick();
    n = 0;
    for (int i = 0; i < UIPC + 3; i++) begin
      if (uip) n++;
      @(negedge clk);
    end
    nchk++;
    if (n != UIPC) begin
      nfail++;
      $display("FAIL R3 window length: actual %0d expected %0d", n, UIPC);
    end
    nchk++;
    if (q.size() != 0) begin
      nfail++;
      $display("FAIL R9 %s: actual no update strobe expected one", tag);
      q.delete();
    end
  endtask

  task automatic tick_ignored(input string tag);
    int n;
    pulse_tick();
    n = 0;
    for (int i = 0; i < UIPC + 3; i++) begin
      if (uip) n++;
      @(negedge clk);
    end
    nchk++;
    if (n != 0) begin
      nfail++;
      $display("FAIL %s uip while ignored: actual %0d expected 0", tag, n);
    end
    check_now(tag);
  endtask

  // monitor: compare each update against the scoreboard head
  always @(negedge clk) begin
    if (!rst && update_flag) begin
      if (q.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL R2/R10/R11 unexpected update: actual 1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        check8({e.tag, " sec"},  sec_q,  e.s);
        check8({e.tag, " min"},  min_q,  e.m);
        check8({e.tag, " hour"}, hour_q, e.h);
        check8({e.tag, " wday"}, wday_q, e.wd);
        check8({e.tag, " mday"}, mday_q, e.md);
        check8({e.tag, " mon"},  mon_q,  e.mo);
        check8({e.tag, " year"}, year_q, e.y);
        check8({e.tag, " R8 alarm"}, {7'd0, alarm_flag}, {7'd0, e.al});
        check8({e.tag, " R9 irq"},   {7'd0, irq_flag},   {7'd0, e.ir});
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ms = 0; mm = 0; mh = 0; mwd = 1; mmd = 1; mmo = 1; my = 0;
    @(negedge clk);
    check_now("R1");
    check8("R1 uip", {7'd0, uip}, 8'd0);
    check8("R1 strobes", {5'd0, update_flag, alarm_flag, irq_flag}, 8'd0);

    // alarm out of the way while testing the calendar
    al_s = -1; al_m = -1; al_h = -1;
    wr(4'd1, 8'hC0); wr(4'd3, 8'hC0); wr(4'd5, 8'hC0);

    // R4 year-end carry chain, BCD 24h
    set_time(23, 59, 58, 7, 31, 12, 99);
    tick_expect("R4");
    tick_expect("R4 rollover");
    check_now("R4 after");

    // R5 month lengths and leap years
    set_time(23, 59, 59, 3, 28, 2, 23); tick_expect("R5 feb 2023");
    set_time(23, 59, 59, 4, 28, 2, 24); tick_expect("R5 feb28 2024");
    set_time(23, 59, 59, 5, 29, 2, 24); tick_expect("R5 feb29 2024");
    set_time(23, 59, 59, 2, 28, 2, 0);  tick_expect("R5 feb 2000");
    set_time(23, 59, 59, 6, 30, 4, 25); tick_expect("R5 april");
    set_time(23, 59, 59, 6, 30, 5, 25); tick_expect("R5 may");

    // R6 binary encoding, then re-encoding to BCD
    bin_mode = 1'b1;
    set_time(13, 45, 59, 5, 17, 6, 42); tick_expect("R6 binary");
    bin_mode = 1'b0;
    repeat (2) @(negedge clk);
    check_now("R6 reencode");

    // R7 12-hour form
    hr24 = 1'b0;
    set_time(11, 59, 59, 1, 10, 3, 30); tick_expect("R7 noon");
    check8("R7 noon byte", hour_q, 8'h92);
    set_time(0, 59, 59, 1, 10, 3, 30);  tick_expect("R7 midnight hour");
    check8("R7 one am byte", hour_q, 8'h01);
    set_time(23, 59, 59, 1, 10, 3, 30); tick_expect("R7 day change");
    check8("R7 midnight byte", hour_q, 8'h12);
    hr24 = 1'b1;

    // R8 alarm with don't-care fields
    alarm_ie = 1'b1;
    al_s = 30; wr(4'd1, enc(30));
    set_time(10, 20, 29, 2, 5, 7, 31); tick_expect("R8 sec match");
    tick_expect("R8 no match");
    al_s = 0; al_m = 21; al_h = 10;
    wr(4'd1, enc(0)); wr(4'd3, enc(21)); wr(4'd5, enc(10));
    set_time(10, 20, 59, 2, 5, 7, 31); tick_expect("R8 full match");
    alarm_ie = 1'b0;
    set_time(10, 20, 59, 2, 5, 7, 31); tick_expect("R8 disabled");

    // R9 update interrupt
    update_ie = 1'b1; tick_expect("R9 irq on");
    update_ie = 1'b0; tick_expect("R9 irq off");

    // R2 ticks ignored
    osc_sel = 3'b000; tick_ignored("R2 osc stopped");
    osc_sel = 3'b110; tick_ignored("R2 osc divider reset");
    osc_sel = 3'b010;
    set_mode = 1'b1;  tick_ignored("R2 hold");
    set_mode = 1'b0;

    // R10 load in the last window cycle wins
    pulse_tick();
    repeat (UIPC - 1) @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'd0; wr_data = enc(45);
    @(negedge clk);
    wr_en = 1'b0;
    ms = 45;
    check8("R10 uip closed", {7'd0, uip}, 8'd0);
    repeat (2) @(negedge clk);
    check_now("R10");

    // R11 hold aborts an open window
    pulse_tick();
    repeat (3) @(negedge clk);
    set_mode = 1'b1;
    @(negedge clk);
    check8("R11 uip dropped", {7'd0, uip}, 8'd0);
    repeat (2) @(negedge clk);
    set_mode = 1'b0;
    repeat (UIPC + 2) @(negedge clk);
    check_now("R11");

    // R12 unused select has no effect
    wr(4'd12, 8'h33);
    repeat (2) @(negedge clk);
    check_now("R12");

    tick_expect("R3 resume");
    finish_run();
  end

endmodule